// File: doc/BRIEF.md
# Condition Flag and Program Counter Sequencer

This block sits between decode and fetch in a small 16-bit load/store processor. It holds three one-bit result flags: negative, zero and positive. Every time the datapath writes a register, the block reclassifies the written value and updates the flags. In the same cycle it works out, without any register in the path, the address of the next instruction. That address may be the next sequential word, a branch or jump target inside the current 512-word page, a register-relative jump, a return through the link register R7, or an indirect system call through a vector table at the bottom of memory.

The surrounding core gives the block the current instruction word, its address, and the register write strobe with its data. It also gives the block the base register value that the instruction selects, the contents of R7, and the word that memory returns for the vector address. The block answers with the next PC, a write request for R7 with the return address, and a vector read request with its address. The vector memory is expected to answer in the same cycle. The register file and the fetch timing belong to the surrounding core.

Top module: `ncc_nextpc_unit`

## Requirements
- R1: While reset is asserted and until the first register write after it, the flags read zero=1, negative=0, positive=0.
- R2: A clock edge with `rf_we`=1 sets negative when bit 15 of `rf_wdata` is 1, zero when `rf_wdata` is 0, and positive otherwise. With `rf_we`=0 the flags hold. Exactly one flag is 1 at all times.
- R3: An instruction whose opcode (bits 15:12) is none of 0000, 0100, 1100, 1101 or 1111 gives `next_pc` = `pc_cur`+1 (modulo 2^16), with `link_we`=0 and `vec_req`=0.
- R4: Opcode 0000 is a conditional branch. It carries mask bits n=bit 11, z=bit 10 and p=bit 9. When (N&n)|(Z&z)|(P&p) is 1, `next_pc` = {`pc_cur`[15:9], `instr`[8:0]}. Otherwise `next_pc` = `pc_cur`+1. A branch never links.
- R5: A branch whose mask is 000 is never taken. A branch whose mask is 111 is taken whatever the flags hold.
- R6: Opcode 0100 jumps to {`pc_cur`[15:9], `instr`[8:0]}. When bit 11 is 1 it also raises `link_we`, with `link_data` = `pc_cur`+1.
- R7: Opcode 1100 jumps to `base_val` plus `instr`[5:0], zero-extended. Bit 11 controls the link in the same way as R6.
- R8: Opcode 1101 gives `next_pc` = `r7_val`, with no link and no vector read.
- R9: Opcode 1111 raises `vec_req` with `vec_addr` = {8'h00, `instr`[7:0]}, raises `link_we` with `link_data` = `pc_cur`+1, and gives `next_pc` = `vec_data`.
- R10: `vec_req` is 1 only for opcode 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_cur | input | 16 | Address of the current instruction |
| instr | input | 16 | Current instruction word |
| rf_we | input | 1 | Register file write strobe |
| rf_wdata | input | 16 | Value being written to the register file |
| base_val | input | 16 | Base register value for register-relative jumps |
| r7_val | input | 16 | Current contents of R7 |
| vec_data | input | 16 | Word that memory returns at `vec_addr` |
| next_pc | output | 16 | Address of the next instruction |
| link_we | output | 1 | Write request for R7 |
| link_data | output | 16 | Return address to write into R7 |
| vec_req | output | 1 | Vector table read request |
| vec_addr | output | 16 | Vector table address |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 6-bit zero-extended jump index and an 8-bit vector number. At that size it can sweep every branch mask against every flag state, and it does so at a low and a high page address. It also visits all sixteen opcodes. The PC values include the top word of memory, so the wrap of `pc_cur`+1 and the keeping of the page bits are both in reach. Index, vector and offset fields are driven at zero, at their all-ones values and in between, so every field boundary of the decode is exercised.

// File: rtl/ncc_pkg.sv
package ncc_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
   localparam logic [OPC_W-1:0] OPC_JPAGE  = 4'b0100;
   localparam logic [OPC_W-1:0] OPC_JREG   = 4'b1100;
   localparam logic [OPC_W-1:0] OPC_RETURN = 4'b1101;
   localparam logic [OPC_W-1:0] OPC_SYSCALL = 4'b1111;

   typedef enum logic [2:0] {
      K_SEQ,
      K_BRANCH,
      K_JPAGE,
      K_JREG,
      K_RETURN,
      K_SYSCALL
   } flow_kind_e;

   typedef struct packed {
      logic neg;
      logic zer;
      logic pos;
   } cc_t;

   localparam cc_t CC_RESET = '{neg: 1'b0, zer: 1'b1, pos: 1'b0};
endpackage

// File: rtl/ncc_decode.sv
module ncc_decode
   import ncc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 6,
   parameter int VEC_W  = 8
) (
   input  logic [WORD_W-1:0]           instr,
   output flow_kind_e                  kind,
   output logic [2:0]                  mask,
   output logic                        link_bit,
   output logic [WORD_W-OPC_W-4:0]     offset,
   output logic [IDX_W-1:0]            index,
   output logic [VEC_W-1:0]            vector
);
   localparam int OFF_W  = WORD_W - OPC_W - 3;
   localparam int MASK_HI = WORD_W - OPC_W - 1;

   logic [OPC_W-1:0] opc;

   assign opc      = instr[WORD_W-1 -: OPC_W];
   assign mask     = instr[MASK_HI -: 3];
   assign link_bit = instr[MASK_HI];
   assign offset   = instr[OFF_W-1:0];
   assign index    = instr[IDX_W-1:0];
   assign vector   = instr[VEC_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_BRANCH:  kind = K_BRANCH;
         OPC_JPAGE:   kind = K_JPAGE;
         OPC_JREG:    kind = K_JREG;
         OPC_RETURN:  kind = K_RETURN;
         OPC_SYSCALL: kind = K_SYSCALL;
         default:     kind = K_SEQ;
      endcase
   end
endmodule

// File: rtl/ncc_flags.sv
module ncc_flags
   import ncc_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_value,
   output cc_t               cc
);
   cc_t cc_next;

   always_comb begin
      cc_next.neg = wr_value[WORD_W-1];
      cc_next.zer = (wr_value == '0);
      cc_next.pos = !wr_value[WORD_W-1] && (wr_value != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc <= CC_RESET;
      end else if (wr_en) begin
         cc <= cc_next;
      end
   end
endmodule

// File: rtl/ncc_target.sv
module ncc_target
   import ncc_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int IDX_W      = 6,
   parameter int VEC_W      = 8,
   parameter bit IDX_SIGNED = 1'b0
) (
   input  flow_kind_e                  kind,
   input  logic [2:0]                  mask,
   input  logic                        link_bit,
   input  logic [WORD_W-OPC_W-4:0]     offset,
   input  logic [IDX_W-1:0]            index,
   input  logic [VEC_W-1:0]            vector,
   input  cc_t                         cc,
   input  logic [WORD_W-1:0]           pc_cur,
   input  logic [WORD_W-1:0]           base_val,
   input  logic [WORD_W-1:0]           r7_val,
   input  logic [WORD_W-1:0]           vec_data,
   output logic [WORD_W-1:0]           next_pc,
   output logic                        link_we,
   output logic [WORD_W-1:0]           link_data,
   output logic                        vec_req,
   output logic [WORD_W-1:0]           vec_addr
);
   localparam int OFF_W = WORD_W - OPC_W - 3;

   logic [WORD_W-1:0] pc_inc;
   logic [WORD_W-1:0] page_tgt;
   logic [WORD_W-1:0] idx_ext;
   logic              cond_hit;

   assign pc_inc   = pc_cur + 1'b1;
   assign page_tgt = {pc_cur[WORD_W-1:OFF_W], offset};
   assign cond_hit = (cc.neg & mask[2]) | (cc.zer & mask[1]) | (cc.pos & mask[0]);

   generate
      if (IDX_SIGNED) begin : g_idx_sext
         assign idx_ext = {{(WORD_W-IDX_W){index[IDX_W-1]}}, index};
      end else begin : g_idx_zext
         assign idx_ext = {{(WORD_W-IDX_W){1'b0}}, index};
      end
   endgenerate

   assign vec_addr  = {{(WORD_W-VEC_W){1'b0}}, vector};
   assign link_data = pc_inc;

   always_comb begin
      next_pc = pc_inc;
      link_we = 1'b0;
      vec_req = 1'b0;
      unique case (kind)
         K_BRANCH: begin
            if (cond_hit) next_pc = page_tgt;
         end
         K_JPAGE: begin
            next_pc = page_tgt;
            link_we = link_bit;
         end
         K_JREG: begin
            next_pc = base_val + idx_ext;
            link_we = link_bit;
         end
         K_RETURN: begin
            next_pc = r7_val;
         end
         K_SYSCALL: begin
            next_pc = vec_data;
            link_we = 1'b1;
            vec_req = 1'b1;
         end
         default: begin
            next_pc = pc_inc;
         end
      endcase
   end
endmodule

// File: rtl/ncc_nextpc_unit.sv
module ncc_nextpc_unit
   import ncc_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int IDX_W      = 6,
   parameter int VEC_W      = 8,
   parameter bit IDX_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pc_cur,
   input  logic [WORD_W-1:0] instr,
   input  logic              rf_we,
   input  logic [WORD_W-1:0] rf_wdata,
   input  logic [WORD_W-1:0] base_val,
   input  logic [WORD_W-1:0] r7_val,
   input  logic [WORD_W-1:0] vec_data,
   output logic [WORD_W-1:0] next_pc,
   output logic              link_we,
   output logic [WORD_W-1:0] link_data,
   output logic              vec_req,
   output logic [WORD_W-1:0] vec_addr,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_p
);
   localparam int OFF_W = WORD_W - OPC_W - 3;

   generate
      if (OFF_W < 2) begin : g_bad_word
         $error("ncc_nextpc_unit: WORD_W too small for opcode, mask and offset");
      end
      if (IDX_W < 1 || IDX_W > OFF_W) begin : g_bad_idx
         $error("ncc_nextpc_unit: IDX_W must lie in 1..OFF_W");
      end
      if (VEC_W < 1 || VEC_W > OFF_W) begin : g_bad_vec
         $error("ncc_nextpc_unit: VEC_W must lie in 1..OFF_W");
      end
   endgenerate

   flow_kind_e        kind;
   logic [2:0]        mask;
   logic              link_bit;
   logic [OFF_W-1:0]  offset;
   logic [IDX_W-1:0]  index;
   logic [VEC_W-1:0]  vector;
   cc_t               cc;

   ncc_decode #(
      .WORD_W (WORD_W),
      .IDX_W  (IDX_W),
      .VEC_W  (VEC_W)
   ) u_decode (
      .instr    (instr),
      .kind     (kind),
      .mask     (mask),
      .link_bit (link_bit),
      .offset   (offset),
      .index    (index),
      .vector   (vector)
   );

   ncc_flags #(
      .WORD_W (WORD_W)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rf_we),
      .wr_value (rf_wdata),
      .cc       (cc)
   );

   ncc_target #(
      .WORD_W     (WORD_W),
      .IDX_W      (IDX_W),
      .VEC_W      (VEC_W),
      .IDX_SIGNED (IDX_SIGNED)
   ) u_target (
      .kind      (kind),
      .mask      (mask),
      .link_bit  (link_bit),
      .offset    (offset),
      .index     (index),
      .vector    (vector),
      .cc        (cc),
      .pc_cur    (pc_cur),
      .base_val  (base_val),
      .r7_val    (r7_val),
      .vec_data  (vec_data),
      .next_pc   (next_pc),
      .link_we   (link_we),
      .link_data (link_data),
      .vec_req   (vec_req),
      .vec_addr  (vec_addr)
   );

   assign flag_n = cc.neg;
   assign flag_z = cc.zer;
   assign flag_p = cc.pos;
endmodule

// File: rtl/ncc_nextpc_chk.sv
module ncc_nextpc_chk
   import ncc_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int VEC_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] pc_cur,
   input logic [WORD_W-1:0] instr,
   input logic              rf_we,
   input logic [WORD_W-1:0] rf_wdata,
   input logic [WORD_W-1:0] r7_val,
   input logic [WORD_W-1:0] vec_data,
   input logic [WORD_W-1:0] next_pc,
   input logic              link_we,
   input logic [WORD_W-1:0] link_data,
   input logic              vec_req,
   input logic [WORD_W-1:0] vec_addr,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_p
);
   localparam int LINK_POS = WORD_W - OPC_W - 1;

   logic [OPC_W-1:0] opc;
   logic             seen_write;
   logic             is_ctrl;

   assign opc     = instr[WORD_W-1 -: OPC_W];
   assign is_ctrl = (opc == OPC_BRANCH) || (opc == OPC_JPAGE) || (opc == OPC_JREG) ||
                    (opc == OPC_RETURN) || (opc == OPC_SYSCALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_write <= 1'b0;
      else if (rf_we) seen_write <= 1'b1;
   end

   assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_write |-> (!flag_n && flag_z && !flag_p));

   assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flag_n, flag_z, flag_p}) == 1);

   assert_flag_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> (flag_n == $past(rf_wdata[WORD_W-1])) && (flag_z == ($past(rf_wdata) == '0)));

   assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_we |=> $stable({flag_n, flag_z, flag_p}));

   assert_sequential_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ctrl |-> (next_pc == pc_cur + 1'b1) && !link_we && !vec_req);

   assert_page_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_JPAGE) |-> (link_we == instr[LINK_POS]));

   assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_RETURN) |-> (next_pc == r7_val) && !link_we);

   assert_syscall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_SYSCALL) |-> vec_req && link_we && (next_pc == vec_data) &&
      (link_data == pc_cur + 1'b1) && (vec_addr[WORD_W-1:VEC_W] == '0));

   assert_vec_only_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (opc == OPC_SYSCALL));
endmodule

bind ncc_nextpc_unit ncc_nextpc_chk #(
   .WORD_W (WORD_W),
   .VEC_W  (VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_cur    (pc_cur),
   .instr     (instr),
   .rf_we     (rf_we),
   .rf_wdata  (rf_wdata),
   .r7_val    (r7_val),
   .vec_data  (vec_data),
   .next_pc   (next_pc),
   .link_we   (link_we),
   .link_data (link_data),
   .vec_req   (vec_req),
   .vec_addr  (vec_addr),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_p    (flag_p)
);

// File: tb/ncc_nextpc_unit_tb.sv
module ncc_nextpc_unit_tb;
   logic        clk;
   logic        rst_n;
   logic [15:0] pc_cur;
   logic [15:0] instr;
   logic        rf_we;
   logic [15:0] rf_wdata;
   logic [15:0] base_val;
   logic [15:0] r7_val;
   logic [15:0] vec_data;
   logic [15:0] next_pc;
   logic        link_we;
   logic [15:0] link_data;
   logic        vec_req;
   logic [15:0] vec_addr;
   logic        flag_n;
   logic        flag_z;
   logic        flag_p;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic [2:0] m_cc;

   ncc_nextpc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .instr(instr),
      .rf_we(rf_we), .rf_wdata(rf_wdata), .base_val(base_val),
      .r7_val(r7_val), .vec_data(vec_data), .next_pc(next_pc),
      .link_we(link_we), .link_data(link_data), .vec_req(vec_req),
      .vec_addr(vec_addr), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic write_reg(input logic [15:0] v);
      @(negedge clk);
      rf_we    = 1'b1;
      rf_wdata = v;
      @(negedge clk);
      rf_we    = 1'b0;
      rf_wdata = ~v;
      if (v[15])       m_cc = 3'b100;
      else if (v == 0) m_cc = 3'b010;
      else             m_cc = 3'b001;
      check("R2 flags after write", {13'd0, flag_n, flag_z, flag_p}, {13'd0, m_cc});
   endtask

   task automatic apply(input logic [15:0] pc, input logic [15:0] ins);
      @(negedge clk);
      pc_cur = pc;
      instr  = ins;
      #1;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] pcs [2];
      logic [15:0] vals [3];
      pcs[0] = 16'h0010; pcs[1] = 16'hFFFF;
      vals[0] = 16'h8001; vals[1] = 16'h0000; vals[2] = 16'h7FFF;
      rst_n = 1'b0; rf_we = 1'b0; rf_wdata = 16'h1234; pc_cur = 16'h0;
      instr = 16'h1000; base_val = 16'h0; r7_val = 16'h0; vec_data = 16'h0;
      m_cc = 3'b010;
      repeat (3) @(negedge clk);
      check("R1 flags in reset", {13'd0, flag_n, flag_z, flag_p}, 16'd2);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 flags after reset", {13'd0, flag_n, flag_z, flag_p}, 16'd2);

      // R2: rf_we low, data moving: flags hold
      rf_wdata = 16'hFFFF;
      repeat (2) @(negedge clk);
      check("R2 hold with rf_we low", {13'd0, flag_n, flag_z, flag_p}, 16'd2);

      // R4, R5: every mask against every flag state at two pages
      for (int f = 0; f < 3; f++) begin
         write_reg(vals[f]);
         for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 2; k++) begin
               logic [15:0] exp;
               logic [8:0]  off;
               off = (k == 0) ? 9'h000 : 9'h1FF;
               apply(pcs[k], {4'b0000, m[2:0], off});
               exp = ((m[2:0] & m_cc) != 0) ? {pcs[k][15:9], off} : pcs[k] + 16'd1;
               if (m == 0)      check("R5 empty mask never taken", next_pc, pcs[k] + 16'd1);
               else if (m == 7) check("R5 full mask always taken", next_pc, {pcs[k][15:9], off});
               else             check("R4 branch target", next_pc, exp);
               check("R4 branch no link", {15'd0, link_we}, 16'd0);
               check("R10 branch no vector read", {15'd0, vec_req}, 16'd0);
            end
         end
      end

      // R6: page jumps with and without link
      for (int l = 0; l < 2; l++) begin
         for (int k = 0; k < 2; k++) begin
            logic [8:0] off;
            off = 9'h0A5 ^ {9{k[0]}};
            apply(pcs[k], {4'b0100, l[0], 2'b00, off});
            check("R6 page jump target", next_pc, {pcs[k][15:9], off});
            check("R6 link strobe", {15'd0, link_we}, {15'd0, l[0]});
            if (l == 1) check("R6 link value", link_data, pcs[k] + 16'd1);
         end
      end

      // R7: register-relative jumps, index zero-extended
      for (int b = 0; b < 3; b++) begin
         for (int ix = 0; ix < 64; ix += 21) begin
            logic [15:0] bv;
            bv = (b == 0) ? 16'h0000 : (b == 1) ? 16'h4321 : 16'hFFF0;
            base_val = bv;
            apply(16'h2000, {4'b1100, b[0], 5'b00000, ix[5:0]});
            check("R7 base plus index", next_pc, bv + {10'd0, ix[5:0]});
            check("R7 link strobe", {15'd0, link_we}, {15'd0, b[0]});
         end
      end
      base_val = 16'h0100;
      apply(16'h2000, 16'b1100_1_00000_111111);
      check("R7 all-ones index not sign-extended", next_pc, 16'h013F);
      check("R7 link value", link_data, 16'h2001);

      // R8: return through R7
      for (int r = 0; r < 3; r++) begin
         r7_val = 16'h1111 * (r + 1) + 16'h000F * r;
         apply(16'h3456, {4'b1101, 12'h000});
         check("R8 return target", next_pc, r7_val);
         check("R8 no link", {15'd0, link_we, vec_req}, 16'd0);
      end

      // R9: system call through low-memory vector
      for (int v = 0; v < 256; v += 85) begin
         vec_data = 16'hA000 + v[15:0];
         apply(pcs[v[0]], {4'b1111, 4'b0000, v[7:0]});
         check("R9 vector address", vec_addr, {8'h00, v[7:0]});
         check("R9 vector request", {15'd0, vec_req}, 16'd1);
         check("R9 target from vector", next_pc, 16'hA000 + v[15:0]);
         check("R9 link strobe", {15'd0, link_we}, 16'd1);
         check("R9 link value", link_data, pcs[v[0]] + 16'd1);
      end

      // R3, R10: all non-control opcodes advance sequentially
      vec_data = 16'hBEEF; r7_val = 16'hCAFE; base_val = 16'h5555;
      for (int o = 0; o < 16; o++) begin
         if (o != 0 && o != 4 && o != 12 && o != 13 && o != 15) begin
            for (int k = 0; k < 2; k++) begin
               apply(pcs[k], {o[3:0], 12'hFFF});
               check("R3 sequential next pc", next_pc, pcs[k] + 16'd1);
               check("R3 no link", {15'd0, link_we}, 16'd0);
               check("R10 no vector read", {15'd0, vec_req}, 16'd0);
            end
         end
      end

      // R2: back-to-back writes switch flags each edge
      write_reg(16'h0001);
      write_reg(16'hFFFF);
      write_reg(16'h0000);
      finish_run();
   end
endmodule